// File: doc/BRIEF.md
# Instruction Window Dependence Analyser

This block inspects a short window of decoded instructions, held in program order, and reports how they constrain one another. Each slot carries an occupancy bit, an optional destination register and up to two optional source registers. When the load strobe is seen, the block compares every earlier slot with every later slot. It records three separate edge matrices: read-after-write (true data), write-after-read (anti) and write-after-write (output). It also flags the slots that have no incoming edge of any kind, so a scheduler can issue those first.

After the edge matrices are captured, the block extends the true-data matrix into its transitive closure. It does this one pass per clock over a fixed number of passes, then pulses a done flag. All results stay registered until the next load, so a scheduler or a profiling unit can read them at leisure. Every matrix uses one flat vector with bit `j*WIN + i` set when slot `j` depends on slot `i`.

Top module: `dep_graph_builder`

## Requirements
- R1: A load strobe sampled at a rising edge captures the window. From the next cycle, raw_mat, war_mat, waw_mat and ready_vec show that window, where bit j*WIN+i means slot j depends on earlier slot i.
- R2: raw_mat bit j*WIN+i is set when slot i has a valid destination and slot j has a valid source (first or second) naming that same register.
- R3: war_mat bit j*WIN+i is set when slot j has a valid destination naming a register that slot i reads through a valid source.
- R4: waw_mat bit j*WIN+i is set when slots i and j both have valid destinations naming the same register.
- R5: Edges run only forward, so no bit with i >= j is ever set in any matrix. A slot whose occupancy bit is low takes part in no edge, and a slot with its destination-valid bit low is never a producer in R2 and never a writer in R3 or R4.
- R6: When done is high, clos_mat bit j*WIN+i is set exactly when a chain of raw_mat edges leads from slot i to slot j.
- R7: ready_vec bit j is set exactly when slot j is occupied and has no incoming raw, war or waw edge.
- R8: done rises WIN-1 cycles after the edge that sampled the load, stays high for exactly one cycle, and the closure then holds its value until the next load.
- R9: A synchronous reset clears every matrix, ready_vec and done to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| load | input | 1 | capture the window on this edge |
| slot_valid | input | WIN | slot occupied |
| dst_valid | input | WIN | slot writes a register |
| dst_reg | input | WIN*RW | destination register, slot k at bits k*RW +: RW |
| srca_valid | input | WIN | first source present |
| srca_reg | input | WIN*RW | first source register |
| srcb_valid | input | WIN | second source present |
| srcb_reg | input | WIN*RW | second source register |
| raw_mat | output | WIN*WIN | true data edges |
| war_mat | output | WIN*WIN | anti edges |
| waw_mat | output | WIN*WIN | output edges |
| clos_mat | output | WIN*WIN | transitive closure of raw_mat |
| ready_vec | output | WIN | occupied slots with no incoming edge |
| done | output | 1 | closure complete, one-cycle pulse |

## Verification
A wrong register comparison or a mixed-up slot index shows up in the first cycle after the load as a wrong bit in one of the edge matrices or in ready_vec. A fault in the closure pass or its pass counter shows only when done rises, WIN-1 cycles later. It appears as a missing or extra indirect edge in clos_mat, or as done arriving a cycle early or late. Chains whose length reaches the window depth, mixed with slots that are empty or have no destination, are what expose too few passes or a leaking empty slot.

// File: rtl/dgb_pkg.sv
package dgb_pkg;
  localparam int DGB_WIN_DEF  = 8;
  localparam int DGB_REGS_DEF = 32;

  // flat index of the edge "consumer j depends on producer i"
  function automatic int edge_idx(input int j, input int i, input int win);
    return j * win + i;
  endfunction
endpackage

// File: rtl/dgb_pair_compare.sv
module dgb_pair_compare #(
  parameter int WIN = dgb_pkg::DGB_WIN_DEF,
  parameter int RW  = 5
) (
  input  logic [WIN-1:0]     slot_valid,
  input  logic [WIN-1:0]     dst_valid,
  input  logic [WIN*RW-1:0]  dst_reg,
  input  logic [WIN-1:0]     srca_valid,
  input  logic [WIN*RW-1:0]  srca_reg,
  input  logic [WIN-1:0]     srcb_valid,
  input  logic [WIN*RW-1:0]  srcb_reg,
  output logic [WIN*WIN-1:0] raw_c,
  output logic [WIN*WIN-1:0] war_c,
  output logic [WIN*WIN-1:0] waw_c
);
  import dgb_pkg::*;

  for (genvar j = 0; j < WIN; j++) begin : g_cons
    for (genvar i = 0; i < WIN; i++) begin : g_prod
      if (i < j) begin : g_fwd
        logic both_live, i_wr, j_wr, j_rd_i, i_rd_j;
        assign both_live = slot_valid[i] & slot_valid[j];
        assign i_wr = both_live & dst_valid[i];
        assign j_wr = both_live & dst_valid[j];
        assign j_rd_i = (srca_valid[j] && srca_reg[j*RW +: RW] == dst_reg[i*RW +: RW]) ||
                        (srcb_valid[j] && srcb_reg[j*RW +: RW] == dst_reg[i*RW +: RW]);
        assign i_rd_j = (srca_valid[i] && srca_reg[i*RW +: RW] == dst_reg[j*RW +: RW]) ||
                        (srcb_valid[i] && srcb_reg[i*RW +: RW] == dst_reg[j*RW +: RW]);
        assign raw_c[edge_idx(j, i, WIN)] = i_wr & j_rd_i;
        assign war_c[edge_idx(j, i, WIN)] = j_wr & i_rd_j;
        assign waw_c[edge_idx(j, i, WIN)] = i_wr & j_wr &
                                            (dst_reg[i*RW +: RW] == dst_reg[j*RW +: RW]);
      end else begin : g_none
        assign raw_c[edge_idx(j, i, WIN)] = 1'b0;
        assign war_c[edge_idx(j, i, WIN)] = 1'b0;
        assign waw_c[edge_idx(j, i, WIN)] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dgb_closure.sv
module dgb_closure #(
  parameter int WIN = dgb_pkg::DGB_WIN_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIN*WIN-1:0] seed,
  input  logic [WIN*WIN-1:0] raw_q,
  output logic [WIN*WIN-1:0] clos,
  output logic               done
);
  import dgb_pkg::*;

  localparam int PW = (WIN > 2) ? $clog2(WIN) : 1;
  localparam logic [PW-1:0] PASSES = PW'(WIN - 1);

  logic [PW-1:0]      passes_left;
  logic [WIN*WIN-1:0] clos_nxt;

  // one step: extend every known path by one direct edge at the consumer end
  always_comb begin
    clos_nxt = clos;
    for (int j = 0; j < WIN; j++)
      for (int i = 0; i < WIN; i++)
        for (int k = 0; k < WIN; k++)
          clos_nxt[edge_idx(j, i, WIN)] = clos_nxt[edge_idx(j, i, WIN)] |
                                          (raw_q[edge_idx(j, k, WIN)] & clos[edge_idx(k, i, WIN)]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clos        <= '0;
      passes_left <= '0;
      done        <= 1'b0;
    end else if (start) begin
      clos        <= seed;
      passes_left <= PASSES;
      done        <= 1'b0;
    end else if (passes_left != '0) begin
      clos        <= clos_nxt;
      passes_left <= passes_left - 1'b1;
      done        <= (passes_left == PW'(1));
    end else begin
      done        <= 1'b0;
    end
  end

  // closure must cover every direct edge once complete
  assert_closure_covers_raw_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> ((raw_q & ~clos) == '0));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_closure_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(clos));

  for (genvar j = 0; j < WIN; j++) begin : g_chk
    for (genvar i = j; i < WIN; i++) begin : g_chk_i
      assert_closure_forward_R5: assert property (@(posedge clk) disable iff (rst)
        !clos[j*WIN + i]);
    end
  end
endmodule

// File: rtl/dep_graph_builder.sv
module dep_graph_builder #(
  parameter int WIN  = dgb_pkg::DGB_WIN_DEF,
  parameter int REGS = dgb_pkg::DGB_REGS_DEF,
  localparam int RW  = $clog2(REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [WIN-1:0]     slot_valid,
  input  logic [WIN-1:0]     dst_valid,
  input  logic [WIN*RW-1:0]  dst_reg,
  input  logic [WIN-1:0]     srca_valid,
  input  logic [WIN*RW-1:0]  srca_reg,
  input  logic [WIN-1:0]     srcb_valid,
  input  logic [WIN*RW-1:0]  srcb_reg,
  output logic [WIN*WIN-1:0] raw_mat,
  output logic [WIN*WIN-1:0] war_mat,
  output logic [WIN*WIN-1:0] waw_mat,
  output logic [WIN*WIN-1:0] clos_mat,
  output logic [WIN-1:0]     ready_vec,
  output logic               done
);
  logic [WIN*WIN-1:0] raw_c, war_c, waw_c, any_c;
  logic [WIN-1:0]     ready_c;

  dgb_pair_compare #(.WIN(WIN), .RW(RW)) u_pairs (
    .slot_valid (slot_valid),
    .dst_valid  (dst_valid),
    .dst_reg    (dst_reg),
    .srca_valid (srca_valid),
    .srca_reg   (srca_reg),
    .srcb_valid (srcb_valid),
    .srcb_reg   (srcb_reg),
    .raw_c      (raw_c),
    .war_c      (war_c),
    .waw_c      (waw_c)
  );

  assign any_c = raw_c | war_c | waw_c;

  for (genvar j = 0; j < WIN; j++) begin : g_ready
    assign ready_c[j] = slot_valid[j] & ~(|any_c[j*WIN +: WIN]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_mat   <= '0;
      war_mat   <= '0;
      waw_mat   <= '0;
      ready_vec <= '0;
    end else if (load) begin
      raw_mat   <= raw_c;
      war_mat   <= war_c;
      waw_mat   <= waw_c;
      ready_vec <= ready_c;
    end
  end

  dgb_closure #(.WIN(WIN)) u_clos (
    .clk   (clk),
    .rst   (rst),
    .start (load),
    .seed  (raw_c),
    .raw_q (raw_mat),
    .clos  (clos_mat),
    .done  (done)
  );

  for (genvar j = 0; j < WIN; j++) begin : g_rdy_chk
    assert_ready_no_incoming_R7: assert property (@(posedge clk) disable iff (rst)
      ready_vec[j] |-> ((raw_mat[j*WIN +: WIN] | war_mat[j*WIN +: WIN] |
                         waw_mat[j*WIN +: WIN]) == '0));
  end

  assert_hold_between_loads_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> ($stable(raw_mat) && $stable(war_mat) && $stable(waw_mat)));
endmodule

// File: tb/dep_graph_builder_test.sv
module dep_graph_builder_test;
  localparam int WIN = 8;
  localparam int REGS = 32;
  localparam int RW = 5;
  localparam int N = WIN * WIN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [WIN-1:0] slot_valid = '0, dst_valid = '0, srca_valid = '0, srcb_valid = '0;
  logic [WIN*RW-1:0] dst_reg = '0, srca_reg = '0, srcb_reg = '0;
  logic [N-1:0] raw_mat, war_mat, waw_mat, clos_mat;
  logic [WIN-1:0] ready_vec;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dep_graph_builder #(.WIN(WIN), .REGS(REGS)) uut (
    .clk(clk), .rst(rst), .load(load),
    .slot_valid(slot_valid), .dst_valid(dst_valid), .dst_reg(dst_reg),
    .srca_valid(srca_valid), .srca_reg(srca_reg),
    .srcb_valid(srcb_valid), .srcb_reg(srcb_reg),
    .raw_mat(raw_mat), .war_mat(war_mat), .waw_mat(waw_mat),
    .clos_mat(clos_mat), .ready_vec(ready_vec), .done(done)
  );

  logic [N-1:0] e_raw, e_war, e_waw, e_clos;
  logic [WIN-1:0] e_ready;

  function automatic logic [RW-1:0] fld(input logic [WIN*RW-1:0] v, input int k);
    return v[k*RW +: RW];
  endfunction

  // reference model from the written rules; closure by Warshall's method
  task automatic build_expect();
    e_raw = '0; e_war = '0; e_waw = '0;
    for (int j = 0; j < WIN; j++)
      for (int i = 0; i < j; i++)
        if (slot_valid[i] && slot_valid[j]) begin
          if (dst_valid[i] &&
              ((srca_valid[j] && fld(srca_reg, j) == fld(dst_reg, i)) ||
               (srcb_valid[j] && fld(srcb_reg, j) == fld(dst_reg, i))))
            e_raw[j*WIN+i] = 1'b1;
          if (dst_valid[j] &&
              ((srca_valid[i] && fld(srca_reg, i) == fld(dst_reg, j)) ||
               (srcb_valid[i] && fld(srcb_reg, i) == fld(dst_reg, j))))
            e_war[j*WIN+i] = 1'b1;
          if (dst_valid[i] && dst_valid[j] && fld(dst_reg, i) == fld(dst_reg, j))
            e_waw[j*WIN+i] = 1'b1;
        end
    e_clos = e_raw;
    for (int k = 0; k < WIN; k++)
      for (int j = 0; j < WIN; j++)
        for (int i = 0; i < WIN; i++)
          if (e_clos[j*WIN+k] && e_clos[k*WIN+i]) e_clos[j*WIN+i] = 1'b1;
    for (int j = 0; j < WIN; j++)
      e_ready[j] = slot_valid[j] &&
                   ((e_raw[j*WIN +: WIN] | e_war[j*WIN +: WIN] | e_waw[j*WIN +: WIN]) == '0);
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // load the window, then follow the full closure sequence
  task automatic run_window();
    build_expect();
    @(negedge clk) load = 1'b1;
    @(posedge clk);
    @(negedge clk) load = 1'b0;
    chk("R2 raw", raw_mat, e_raw);
    chk("R3 war", war_mat, e_war);
    chk("R4 waw", waw_mat, e_waw);
    chk("R7 ready", N'(ready_vec), N'(e_ready));
    chk("R8 done low after load", N'(done), '0);
    repeat (WIN - 2) @(posedge clk);
    @(negedge clk);
    chk("R8 done not early", N'(done), '0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 done high", N'(done), N'(1));
    chk("R6 closure", clos_mat, e_clos);
    @(posedge clk);
    @(negedge clk);
    chk("R8 done one cycle", N'(done), '0);
    chk("R8 closure held", clos_mat, e_clos);
    chk("R1 matrices held", raw_mat, e_raw);
  endtask

  task automatic set_slot(input int k, input bit v, input bit dv, input int d,
                          input bit av, input int a, input bit bv, input int b);
    slot_valid[k] = v; dst_valid[k] = dv; dst_reg[k*RW +: RW] = RW'(d);
    srca_valid[k] = av; srca_reg[k*RW +: RW] = RW'(a);
    srcb_valid[k] = bv; srcb_reg[k*RW +: RW] = RW'(b);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R9 reset state
    chk("R9 reset raw", raw_mat, '0);
    chk("R9 reset clos", clos_mat, '0);
    chk("R9 reset ready", N'(ready_vec), '0);
    chk("R9 reset done", N'(done), '0);

    // R2 R3 R4: load/add/store pair sequence sharing names
    set_slot(0, 1, 1, 0, 1, 1, 0, 0);
    set_slot(1, 1, 1, 4, 1, 0, 1, 2);
    set_slot(2, 1, 0, 0, 1, 4, 1, 1);
    set_slot(3, 1, 1, 0, 1, 1, 0, 0);
    set_slot(4, 1, 1, 4, 1, 0, 1, 2);
    set_slot(5, 1, 0, 0, 1, 4, 1, 1);
    set_slot(6, 0, 1, 4, 1, 0, 1, 4);
    set_slot(7, 0, 1, 0, 1, 4, 0, 0);
    run_window();

    // R6: full-depth chain 0->1->...->7 through one register each step
    for (int k = 0; k < WIN; k++) set_slot(k, 1, 1, k + 1, (k > 0), k, 0, 0);
    run_window();
    chk("R6 longest chain edge", N'(clos_mat[(WIN-1)*WIN + 0]), N'(1));

    // R5: no destination anywhere, same source everywhere: no edges
    for (int k = 0; k < WIN; k++) set_slot(k, 1, 0, 3, 1, 3, 1, 3);
    run_window();
    chk("R5 R7 all ready", N'(ready_vec), N'({WIN{1'b1}}));

    // R5: every slot empty though fields collide
    for (int k = 0; k < WIN; k++) set_slot(k, 0, 1, 2, 1, 2, 1, 2);
    run_window();

    // random windows over few registers for many collisions
    for (int t = 0; t < 150; t++) begin
      for (int k = 0; k < WIN; k++)
        set_slot(k, ($urandom % 8) != 0, ($urandom % 4) != 0, $urandom % 4,
                 ($urandom % 3) != 0, $urandom % 4, ($urandom % 2) != 0, $urandom % 4);
      run_window();
    end

    // R1: reload in mid-closure restarts on the new window
    for (int k = 0; k < WIN; k++) set_slot(k, 1, 1, 5, 1, 5, 0, 0);
    @(negedge clk) load = 1'b1;
    @(posedge clk);
    @(negedge clk) load = 1'b0;
    repeat (2) @(posedge clk);
    for (int k = 0; k < WIN; k++) set_slot(k, 1, 1, k, 0, 0, 0, 0);
    run_window();
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule